// File: doc/BRIEF.md
# Latched Priority Interrupt Arbiter

This block sits between a group of level-sensitive peripheral interrupt request lines and a small processor core. It takes a decision only when the core reports that an instruction has completed, so a request never cuts into an instruction. At that boundary, a hardware source is eligible when the global mask is clear and the source's own enable bit is set. The lowest-indexed eligible source wins. A software-interrupt request from the core ignores both the mask and the enables.

The winner is held in a latch together with a constant vector code. The core uses that code to choose which service address to fetch. While the latch is full, nothing can replace the winner, whatever its priority. The latch empties when the core pulses its service acknowledge, which also sets the global mask to block further maskable requests. It also empties if the core clears the mask before acknowledging.

A mask clear that arrives with an instruction boundary already counts for that boundary. This lets a request still pending when a service routine returns be taken before the interrupted program resumes.

Top module: `irq_arb_top`

## Requirements
- R1: A synchronous active-high reset empties the latch (`int_take` low, `vec_code` 0) and sets `gmask` to 1.
- R2: The latch is loaded only on a clock edge where `insn_done` is high and the latch is empty; requests present in other cycles do not change `int_take`.
- R3: At a boundary, hardware source i is eligible only when `irq_req[i]` and `irq_en[i]` are both 1 and the effective mask is clear. The effective mask is clear when `gmask` is 0 or `mask_clr` is high in that cycle. With no eligible source and no software request, the latch stays empty.
- R4: Among eligible sources, the lowest index wins, and `vec_code` equals that index.
- R5: A `swi_req` at a boundary is latched whatever `gmask` and `irq_en` hold, with `vec_code` = NUM_SRC. It wins over any hardware source at the same boundary.
- R6: While the latch is full and neither `svc_ack` nor `mask_clr` is high, `int_take` stays 1 and `vec_code` keeps its value, whatever new requests or boundaries arrive.
- R7: `svc_ack` empties a full latch in the next cycle and sets `gmask` to 1.
- R8: `mask_clr` while the latch is full and `svc_ack` is low empties the latch in the next cycle. No new winner is latched on that edge.
- R9: `gmask` update priority: `svc_ack` sets it, otherwise `mask_clr` clears it, otherwise `mask_set` sets it, otherwise it holds.
- R10: A boundary that coincides with `mask_clr` latches a pending eligible request on that edge, as happens on return from a service routine.
- R11: Requests are level-sensitive. A request that drops before the next boundary is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Level request per source, bit 0 highest priority |
| irq_en | input | NUM_SRC | Per-source enable |
| insn_done | input | 1 | Core reports instruction completion (boundary) |
| swi_req | input | 1 | Software-interrupt instruction completing, non-maskable |
| svc_ack | input | 1 | One-cycle pulse: core starts servicing the latched request |
| mask_clr | input | 1 | Core clears the global mask |
| mask_set | input | 1 | Core sets the global mask |
| int_take | output | 1 | Latch full: core must enter the interrupt sequence |
| vec_code | output | $clog2(NUM_SRC+1) | Vector code of the latched winner (NUM_SRC for software) |
| gmask | output | 1 | Global interrupt mask state |

## Verification
Several eligible sources are raised together with different enable patterns. This shows whether priority follows the index and whether disabled sources are skipped. A higher-priority request raised while a winner is held, with boundaries still arriving, shows whether the latch can be preempted. Requests are also held with the mask set, raised and dropped between boundaries, and paired with a software request. These separate mask gating, level sampling and software precedence. Finally, a boundary coinciding with a mask clear, and a mask clear on a full latch, show the return-from-service path apart from the drop-on-clear path.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  function automatic int unsigned code_width(input int unsigned n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/irq_eligible.sv
module irq_eligible #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] en,
  input  logic               mask_eff,
  output logic [NUM_SRC-1:0] elig
);
  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_gate
      assign elig[i] = req[i] & en[i] & ~mask_eff;
    end
  endgenerate
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned CW      = 4
) (
  input  logic [NUM_SRC-1:0] elig,
  output logic               any,
  output logic [CW-1:0]      idx
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] grant;

  assign seen[0] = 1'b0;
  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_chain
      assign grant[i]  = elig[i] & ~seen[i];
      assign seen[i+1] = seen[i] | elig[i];
    end
  endgenerate

  assign any = seen[NUM_SRC];

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant[k]) idx = idx | CW'(k);
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_done,
  input  logic          swi_req,
  input  logic          hw_any,
  input  logic [CW-1:0] hw_idx,
  input  logic          svc_ack,
  input  logic          mask_clr,
  input  logic          mask_set,
  output logic          valid,
  output logic [CW-1:0] code,
  output logic          gmask
);
  localparam logic [CW-1:0] SWI_CODE = CW'(NUM_SRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      code  <= '0;
      gmask <= 1'b1;
    end else begin
      if (svc_ack)       gmask <= 1'b1;
      else if (mask_clr) gmask <= 1'b0;
      else if (mask_set) gmask <= 1'b1;

      if (valid) begin
        if (svc_ack || mask_clr) valid <= 1'b0;
      end else if (insn_done) begin
        if (swi_req) begin
          valid <= 1'b1;
          code  <= SWI_CODE;
        end else if (hw_any) begin
          valid <= 1'b1;
          code  <= hw_idx;
        end
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!valid && gmask && code == '0));

  assert_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    (!valid && !insn_done) |=> !valid);

  assert_swi_R5: assert property (@(posedge clk) disable iff (rst)
    (!valid && insn_done && swi_req) |=> (valid && code == SWI_CODE));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !svc_ack && !mask_clr) |=> (valid && $stable(code)));

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && svc_ack) |=> (!valid && gmask));

  assert_mask_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && !svc_ack && mask_clr) |=> !valid);

  assert_mask_prio_R9: assert property (@(posedge clk) disable iff (rst)
    (!svc_ack && mask_clr) |=> !gmask);
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned CW     = code_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               insn_done,
  input  logic               swi_req,
  input  logic               svc_ack,
  input  logic               mask_clr,
  input  logic               mask_set,
  output logic               int_take,
  output logic [CW-1:0]      vec_code,
  output logic               gmask
);
  logic               mask_eff;
  logic [NUM_SRC-1:0] elig;
  logic               hw_any;
  logic [CW-1:0]      hw_idx;

  // A clear arriving with the boundary counts for that boundary.
  assign mask_eff = gmask & ~mask_clr;

  irq_eligible #(.NUM_SRC(NUM_SRC)) u_elig (
    .req      (irq_req),
    .en       (irq_en),
    .mask_eff (mask_eff),
    .elig     (elig)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .CW(CW)) u_prio (
    .elig (elig),
    .any  (hw_any),
    .idx  (hw_idx)
  );

  irq_latch #(.NUM_SRC(NUM_SRC), .CW(CW)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .insn_done (insn_done),
    .swi_req   (swi_req),
    .hw_any    (hw_any),
    .hw_idx    (hw_idx),
    .svc_ack   (svc_ack),
    .mask_clr  (mask_clr),
    .mask_set  (mask_set),
    .valid     (int_take),
    .code      (vec_code),
    .gmask     (gmask)
  );

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!int_take && insn_done && !swi_req && gmask && !mask_clr) |=> !int_take);

  assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (!int_take && insn_done && !swi_req && ((irq_req & irq_en) == '0)) |=> !int_take);

  assert_level_R11: assert property (@(posedge clk) disable iff (rst)
    (!int_take && irq_req == '0 && !swi_req) |=> !int_take);
endmodule

// File: tb/irq_arb_top_tb.sv
module irq_arb_top_tb;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_req = '0;
  logic [N-1:0]  irq_en  = '0;
  logic          insn_done = 1'b0, swi_req = 1'b0, svc_ack = 1'b0;
  logic          mask_clr = 1'b0, mask_set = 1'b0;
  logic          int_take;
  logic [CW-1:0] vec_code;
  logic          gmask;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state
  bit        m_valid = 1'b0;
  int        m_code  = 0;
  bit        m_mask  = 1'b1;

  always #5 clk = ~clk;

  irq_arb_top #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .insn_done(insn_done), .swi_req(swi_req), .svc_ack(svc_ack),
    .mask_clr(mask_clr), .mask_set(mask_set),
    .int_take(int_take), .vec_code(vec_code), .gmask(gmask)
  );

  always @(posedge clk) begin
    bit nv; int nc; bit nm; bit eff;
    if (rst) begin
      m_valid = 0; m_code = 0; m_mask = 1;
    end else begin
      nv = m_valid; nc = m_code; nm = m_mask;
      eff = m_mask && !mask_clr;
      if (svc_ack) nm = 1;
      else if (mask_clr) nm = 0;
      else if (mask_set) nm = 1;
      if (m_valid) begin
        if (svc_ack || mask_clr) nv = 0;
      end else if (insn_done) begin
        if (swi_req) begin
          nv = 1; nc = N;
        end else if (!eff) begin
          for (int i = N - 1; i >= 0; i--)
            if (irq_req[i] && irq_en[i]) begin nv = 1; nc = i; end
        end
      end
      m_valid = nv; m_code = nc; m_mask = nm;
    end
  end

  task automatic compare();
    checks++;
    if (int_take !== m_valid || gmask !== m_mask ||
        (m_valid && int'(vec_code) != m_code) || (!m_valid && rst_done_code_bad())) begin
      errors++;
      $display("FAIL %s: take=%0b code=%0d mask=%0b expected take=%0b code=%0d mask=%0b",
               tag, int_take, vec_code, gmask, m_valid, m_code, m_mask);
    end
  endtask

  function automatic bit rst_done_code_bad();
    return (tag == "R1") && (vec_code !== '0);
  endfunction

  // advance one cycle: check outputs, then drive next inputs
  task automatic step(input string t, input logic [N-1:0] rq, input logic [N-1:0] en,
                      input bit d, input bit s, input bit a, input bit c, input bit ms);
    @(negedge clk);
    compare();
    tag = t;
    irq_req = rq; irq_en = en; insn_done = d; swi_req = s;
    svc_ack = a; mask_clr = c; mask_set = ms;
  endtask

  task automatic idle(input string t, input int n);
    for (int k = 0; k < n; k++) step(t, irq_req, irq_en, 0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step("R1", '0, '0, 0, 0, 0, 0, 0);
        // R3: mask set after reset blocks an enabled request
        step("R3", 8'h10, 8'hFF, 1, 0, 0, 0, 0);
        idle("R3", 2);
        // clear mask, hold requests without a boundary (R2)
        step("R9", 8'h00, 8'hFF, 0, 0, 0, 1, 0);
        step("R2", 8'h24, 8'hFF, 0, 0, 0, 0, 0);
        idle("R2", 3);
        // boundary: lowest index wins (R4) -> code 2
        step("R4", 8'h24, 8'hFF, 1, 0, 0, 0, 0);
        idle("R4", 1);
        // higher priority arrives with boundaries: no preemption (R6)
        step("R6", 8'h25, 8'hFF, 1, 0, 0, 0, 0);
        step("R6", 8'h25, 8'hFF, 1, 0, 0, 0, 0);
        idle("R6", 2);
        // ack clears and sets mask (R7)
        step("R7", 8'h00, 8'hFF, 0, 0, 1, 0, 0);
        idle("R7", 2);
        // disabled source skipped (R3), then enabled lower-priority one (R4)
        step("R9", 8'h00, 8'hF7, 0, 0, 0, 1, 0);
        step("R3", 8'h08, 8'hF7, 1, 0, 0, 0, 0);
        idle("R3", 1);
        step("R4", 8'h48, 8'hF7, 1, 0, 0, 0, 0);
        idle("R4", 1);
        // mask clear while held drops the latch (R8)
        step("R8", 8'h48, 8'hF7, 1, 0, 0, 1, 0);
        idle("R8", 1);
        step("R8", 8'h00, 8'hFF, 0, 0, 0, 0, 1);
        // SWI with mask set (R5) -> code N
        step("R5", 8'h00, 8'h00, 1, 1, 0, 0, 0);
        idle("R5", 1);
        step("R7", 8'h00, 8'hFF, 0, 0, 1, 0, 0);
        // SWI beats hardware, mask clear
        step("R9", 8'h00, 8'hFF, 0, 0, 0, 1, 0);
        step("R5", 8'h01, 8'hFF, 1, 1, 0, 0, 0);
        idle("R5", 1);
        step("R7", 8'h00, 8'hFF, 0, 0, 1, 0, 0);
        // return path: pending request taken at boundary with mask clear (R10)
        step("R10", 8'h02, 8'hFF, 0, 0, 0, 0, 0);
        step("R10", 8'h02, 8'hFF, 1, 0, 0, 1, 0);
        idle("R10", 1);
        step("R7", 8'h00, 8'hFF, 0, 0, 1, 0, 0);
        // level sensitivity (R11)
        step("R9", 8'h00, 8'hFF, 0, 0, 0, 1, 1);
        step("R11", 8'h80, 8'hFF, 0, 0, 0, 0, 0);
        step("R11", 8'h80, 8'hFF, 0, 0, 0, 0, 0);
        step("R11", 8'h00, 8'hFF, 0, 0, 0, 0, 0);
        step("R11", 8'h00, 8'hFF, 1, 0, 0, 0, 0);
        idle("R11", 2);
        // mask_set alone (R9)
        step("R9", 8'h00, 8'hFF, 0, 0, 0, 0, 1);
        idle("R9", 2);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule